// File: doc/BRIEF.md
# Serial Peripheral Master with Queued Words

The block is a master-side synchronous serial port. Software writes bytes into an 8-deep transmit queue. A shift engine sends each byte MSB first on a serial clock that idles low. Data changes after a falling edge and the input line is sampled on each rising edge. Each byte captured from the input line goes into an 8-deep receive queue, which software drains through the same data address.

The serial bit clock is produced in two stages. The first stage divides the system clock by an even divisor from 2 to 254. The second stage divides again by a rate field plus one. The engine never starts a frame while the divisor is below 2.

A read-only status word reports queue levels and activity. Four interrupt conditions are each gated by an enable bit:
- receive overrun
- receive idle timeout
- receive queue at least half full
- transmit queue at least half empty

Register map (3-bit address):
- 0: data. A write pushes a byte onto the transmit queue. A read pops a byte from the receive queue.
- 1: rate field [7:0].
- 2: status.
- 3: divisor.
- 4: interrupt enables [3:0].
- 5: raw conditions. Reading returns them. Writing a 1 clears bit 0 (overrun) or bit 1 (timeout count).

Top module: `ssp_master`

## Requirements
- R1: The divisor register resets to 0. A write stores bits [7:1] of the write data, and bit 0 always reads back as 0.
- R2: While the divisor is below 2, no frame starts and queued bytes stay in the transmit queue. Once a valid divisor is written, the queued bytes are sent.
- R3: The serial clock idles low. Its period is divisor × (rate + 1) system clock cycles.
- R4: Frames are 8 bits, MSB first. The output line is stable except at frame start and after a falling clock edge. The input is sampled on rising edges, so a looped-back line returns the sent byte.
- R5: The status bits are: bit0 transmit queue empty, bit1 transmit queue not full, bit2 receive queue not empty, bit3 receive queue full. Bits 31:5 read 0. The status resets to 0x03.
- R6: Status bit4 (busy) is 1 while a frame is in progress or the transmit queue holds data, and 0 otherwise.
- R7: A data write while the transmit queue holds 8 bytes is dropped. Bytes leave each queue in arrival order.
- R8: A byte received while the receive queue is full is discarded and sets raw bit0 (overrun). The bit stays set until a write to address 5 with bit0 set.
- R9: Raw bit1 (timeout) sets when the receive queue is non-empty and TIMEOUT_CYC cycles pass with no push or pop. A pop clears it.
- R10: Raw bit2 is 1 when the receive queue holds at least 4 bytes. Raw bit3 is 1 when the transmit queue holds at most 4 bytes.
- R11: irq_o is the OR of the raw bits ANDed with the enable register, which reads back at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (pops the receive queue at address 0) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check four properties on every cycle:
- the serial clock stays low outside a frame, and the output line changes only at frame start or on a falling edge;
- queue counts move exactly by the accepted pushes and pops, and a push into a full queue leaves the count unchanged;
- a frame never begins while the divisor is below 2;
- a receive into a full queue always leaves overrun set.

Only the bench scenarios can show the rest:
- the measured bit period for each divisor and rate pair;
- byte integrity through loopback;
- queue ordering;
- the timeout delay;
- how the status word and interrupt output react to sequences of writes and reads.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int DW = 8;
  localparam logic [2:0] A_DATA  = 3'd0;
  localparam logic [2:0] A_RATE  = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_PRESC = 3'd3;
  localparam logic [2:0] A_IEN   = 3'd4;
  localparam logic [2:0] A_RAW   = 3'd5;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= rptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R7
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i) |=> (count_o == $past(count_o) + 1'b1));

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(count_o));
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int PW = 8,
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] half_i,
  input  logic [RW-1:0] rate_i,
  output logic          tick_o
);
  logic [PW-1:0] pre_q;
  logic [RW-1:0] rate_q;
  logic          pre_wrap;

  assign pre_wrap = (pre_q == half_i - 1'b1);
  assign tick_o   = run_i && pre_wrap && (rate_q == rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      rate_q <= '0;
    end else if (!run_i) begin
      pre_q  <= '0;
      rate_q <= '0;
    end else if (pre_wrap) begin
      pre_q  <= '0;
      rate_q <= (rate_q == rate_i) ? '0 : rate_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int W = 8,
  localparam int BW = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_ok_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tick_i,
  input  logic         miso_i,
  output logic         tx_pop_o,
  output logic         rx_push_o,
  output logic [W-1:0] rx_data_o,
  output logic         active_o,
  output logic         sck_o,
  output logic         mosi_o
);
  logic          active_q, sck_q;
  logic [W-1:0]  sh_q, rx_q;
  logic [BW-1:0] bit_q;
  logic          last_bit;

  assign last_bit  = (bit_q == BW'(W - 1));
  assign tx_pop_o  = !active_q && start_ok_i;
  assign rx_push_o = active_q && tick_i && sck_q && last_bit;
  assign rx_data_o = rx_q;
  assign active_o  = active_q;
  assign sck_o     = sck_q;
  assign mosi_o    = active_q ? sh_q[W-1] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      sh_q     <= '0;
      rx_q     <= '0;
      bit_q    <= '0;
    end else if (!active_q) begin
      if (start_ok_i) begin
        active_q <= 1'b1;
        sh_q     <= tx_data_i;
        bit_q    <= '0;
        sck_q    <= 1'b0;
      end
    end else if (tick_i) begin
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_q  <= {rx_q[W-2:0], miso_i};
      end else begin
        sck_q <= 1'b0;
        if (last_bit) begin
          active_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {sh_q[W-2:0], 1'b0};
        end
      end
    end
  end

  // R3
  sck_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sck_o);

  // R4
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q) && !$fell(sck_q)) |-> $stable(mosi_o));
endmodule

// File: rtl/ssp_master.sv
module ssp_master #(
  parameter int DEPTH       = 8,
  parameter int TIMEOUT_CYC = 64,
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int TOW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  addr_i,
  input  logic        we_i,
  input  logic        re_i,
  input  logic [7:0]  wdata_i,
  output logic [31:0] rdata_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        irq_o
);
  import ssp_pkg::*;

  localparam logic [CW-1:0]  HALF_C = CW'(DEPTH / 2);
  localparam logic [TOW-1:0] TO_C   = TOW'(TIMEOUT_CYC);

  logic [7:0]    rate_q, presc_q;
  logic [3:0]    ien_q;
  logic          ovr_q;
  logic [TOW-1:0] to_q;

  logic          tx_push, rx_pop, tx_pop, rx_push;
  logic [DW-1:0] tx_data, rx_wdata, rx_rdata;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          presc_ok, active, tick, start_ok, busy;
  logic          clr_ovr, clr_to;
  logic [3:0]    raw;
  logic [4:0]    status;

  assign tx_push  = we_i && (addr_i == A_DATA);
  assign rx_pop   = re_i && (addr_i == A_DATA);
  assign clr_ovr  = we_i && (addr_i == A_RAW) && wdata_i[0];
  assign clr_to   = we_i && (addr_i == A_RAW) && wdata_i[1];
  assign presc_ok = |presc_q[7:1];
  assign start_ok = presc_ok && !tx_empty;
  assign busy     = active || !tx_empty;

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(wdata_i), .pop_i(tx_pop),
    .rdata_o(tx_data), .empty_o(tx_empty), .full_o(tx_full), .count_o(tx_cnt)
  );

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_wdata), .pop_i(rx_pop),
    .rdata_o(rx_rdata), .empty_o(rx_empty), .full_o(rx_full), .count_o(rx_cnt)
  );

  ssp_clkgen #(.PW(8), .RW(8)) u_clk (
    .clk_i, .rst_ni,
    .run_i(active), .half_i({1'b0, presc_q[7:1]}), .rate_i(rate_q), .tick_o(tick)
  );

  ssp_shift #(.W(DW)) u_shift (
    .clk_i, .rst_ni,
    .start_ok_i(start_ok), .tx_data_i(tx_data), .tick_i(tick), .miso_i(miso_i),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_wdata),
    .active_o(active), .sck_o(sck_o), .mosi_o(mosi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q  <= '0;
      presc_q <= '0;
      ien_q   <= '0;
      ovr_q   <= 1'b0;
      to_q    <= '0;
    end else begin
      if (we_i && addr_i == A_RATE)  rate_q  <= wdata_i;
      if (we_i && addr_i == A_PRESC) presc_q <= {wdata_i[7:1], 1'b0};
      if (we_i && addr_i == A_IEN)   ien_q   <= wdata_i[3:0];
      if (rx_push && rx_full)        ovr_q   <= 1'b1;
      else if (clr_ovr)              ovr_q   <= 1'b0;
      // idle counter restarts on any receive queue movement
      if (rx_empty || rx_push || rx_pop || clr_to) to_q <= '0;
      else if (to_q != TO_C)                       to_q <= to_q + 1'b1;
    end
  end

  assign raw    = {tx_cnt <= HALF_C, rx_cnt >= HALF_C, to_q == TO_C, ovr_q};
  assign irq_o  = |(raw & ien_q);
  assign status = {busy, rx_full, !rx_empty, !tx_full, tx_empty};

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_DATA:  rdata_o = rx_empty ? 32'd0 : {24'd0, rx_rdata};
      A_RATE:  rdata_o = {24'd0, rate_q};
      A_STAT:  rdata_o = {27'd0, status};
      A_PRESC: rdata_o = {24'd0, presc_q};
      A_IEN:   rdata_o = {28'd0, ien_q};
      A_RAW:   rdata_o = {28'd0, raw};
      default: rdata_o = '0;
    endcase
  end

  // R2
  no_start_low_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active) |-> ($past(presc_q) >= 8'd2));

  // R8
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full) |=> ovr_q);
endmodule

// File: tb/sim_ssp_master.sv
module sim_ssp_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi, irq;

  int checks = 0, errors = 0;
  int cyc = 0, last_rise = 0, period = 0, rises = 0;
  logic sck_d = 1'b0;

  // {divisor, rate, byte}
  localparam logic [23:0] VEC [6] = '{24'h0200A5, 24'h04013C, 24'h060081,
                                      24'h0203FF, 24'h080000, 24'h0A025A};

  always #2 clk = ~clk;

  ssp_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(mosi), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc++;
    sck_d <= sck;
    if (sck && !sck_d) begin
      period    = cyc - last_rise;
      last_rise = cyc;
      rises++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic pop, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = pop;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd2, 1'b0, s);
      if (!s[4]) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual hung expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(3'd2, 1'b0, d); chk("R5 reset status", d, 32'h03);
    rd(3'd3, 1'b0, d); chk("R1 reset divisor", d, 32'h00);
    rd(3'd5, 1'b0, d); chk("R10 reset raw", d, 32'h08);
    chk("R11 reset irq", {31'd0, irq}, 32'd0);
    wr(3'd3, 8'h07);
    rd(3'd3, 1'b0, d); chk("R1 lsb forced", d, 32'h06);

    // stalled divisor
    wr(3'd3, 8'h01);
    wr(3'd1, 8'h00);
    r0 = rises;
    wr(3'd0, 8'h11);
    repeat (100) @(negedge clk);
    chk("R2 no clock with divisor<2", rises - r0, 0);
    rd(3'd2, 1'b0, d); chk("R6 busy while queued", d, 32'h12);
    wr(3'd3, 8'h02);
    wait_idle();
    rd(3'd2, 1'b0, d); chk("R5 status after rx", d, 32'h07);
    rd(3'd0, 1'b1, d); chk("R2 queued byte sent", d, 32'h11);
    rd(3'd2, 1'b0, d); chk("R6 idle status", d, 32'h03);

    // vector table
    foreach (VEC[i]) begin
      wr(3'd3, VEC[i][23:16]);
      wr(3'd1, VEC[i][15:8]);
      wr(3'd0, VEC[i][7:0]);
      wait_idle();
      rd(3'd0, 1'b1, d); chk("R4 loopback byte", d, {24'd0, VEC[i][7:0]});
      chk("R3 bit period", period, VEC[i][23:16] * (VEC[i][15:8] + 1));
    end
    chk("R3 clock idle low", {31'd0, sck}, 32'd0);

    // fill transmit queue past depth
    wr(3'd3, 8'h00);
    for (int k = 0; k < 9; k++) wr(3'd0, 8'h20 + 8'(k));
    rd(3'd2, 1'b0, d); chk("R7 tx full status", d, 32'h10);
    rd(3'd5, 1'b0, d); chk("R10 tx half empty clear", d & 32'h8, 32'h0);
    wr(3'd3, 8'h02); wr(3'd1, 8'h00);
    wait_idle();
    rd(3'd2, 1'b0, d); chk("R5 rx full status", d, 32'h0F);
    rd(3'd5, 1'b0, d); chk("R10 rx half full", d & 32'hC, 32'hC);
    for (int k = 0; k < 8; k++) begin
      rd(3'd0, 1'b1, d); chk("R7 order", d, 32'h20 + k);
    end
    rd(3'd2, 1'b0, d); chk("R7 ninth write dropped", d, 32'h03);

    // overrun
    wr(3'd3, 8'h00);
    for (int k = 0; k < 8; k++) wr(3'd0, 8'h30 + 8'(k));
    wr(3'd3, 8'h02);
    wait_idle();
    rd(3'd5, 1'b0, d); chk("R8 no overrun yet", d & 32'h1, 32'h0);
    wr(3'd0, 8'h40);
    wait_idle();
    rd(3'd5, 1'b0, d); chk("R8 overrun set", d & 32'h1, 32'h1);
    wr(3'd4, 8'h01);
    rd(3'd4, 1'b0, d); chk("R11 enable readback", d, 32'h1);
    chk("R11 irq on overrun", {31'd0, irq}, 32'd1);
    for (int k = 0; k < 8; k++) begin
      rd(3'd0, 1'b1, d); chk("R8 contents kept", d, 32'h30 + k);
    end
    rd(3'd5, 1'b0, d); chk("R8 overrun sticky", d & 32'h1, 32'h1);
    wr(3'd5, 8'h01);
    rd(3'd5, 1'b0, d); chk("R8 overrun cleared", d & 32'h1, 32'h0);
    chk("R11 irq drops", {31'd0, irq}, 32'd0);

    // receive timeout
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h77);
    wait_idle();
    rd(3'd5, 1'b0, d); chk("R9 no early timeout", d & 32'h2, 32'h0);
    repeat (80) @(negedge clk);
    rd(3'd5, 1'b0, d); chk("R9 timeout set", d & 32'h2, 32'h2);
    chk("R11 irq masked", {31'd0, irq}, 32'd0);
    wr(3'd4, 8'h02);
    chk("R11 irq on timeout", {31'd0, irq}, 32'd1);
    rd(3'd0, 1'b1, d); chk("R9 byte", d, 32'h77);
    rd(3'd5, 1'b0, d); chk("R9 pop clears timeout", d & 32'h2, 32'h0);
    chk("R11 irq cleared", {31'd0, irq}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule